// File: doc/BRIEF.md
# Narrow-to-Wide Registered Bus Exchanger

This block moves data between a narrow port A and a wide port made of two equal halves, 1B and 2B. Toward the wide side, a narrow word enters a two-stage pipeline that feeds 1B, and a single register feeds 2B. Each of these paths loads under its own active-low load strobe. Two narrow words sent on consecutive loads therefore appear side by side as one double-width word: the older word on 1B and the newer word on 2B. Toward the narrow side, each wide half is captured in its own register under its own active-low strobe. A select input chooses which stored half drives A.

Bidirectional pads are modelled as separate input, output and output-enable signals. The two active-low direction controls are sampled on the rising clock edge, so a change of bus direction takes effect only at an edge. When a port is disabled, its output-enable is low and its data outputs are forced to zero. A synchronous active-high reset clears every data register and disables both ports.

Top module: `bus_exchanger_nw`

## Requirements
- R1: While `rst` is high at a rising edge, all data registers clear to zero and both `a_oe` and `b_oe` are 0 after that edge.
- R2: The 1B path is two registers deep. At every edge with `ld_a1_n` low, stage 1 takes `a_in` and `b1_out` takes the old stage-1 value. A word therefore needs two such edges to reach 1B.
- R3: At an edge with `ld_a1_n` high, both 1B pipeline stages keep their contents.
- R4: The 2B register takes `a_in` at an edge with `ld_a2_n` low and holds at an edge with `ld_a2_n` high, independent of `ld_a1_n`.
- R5: Word N is loaded with only `ld_a1_n` low. At the next edge word N+1 is loaded with both strobes low. After that edge, `b1_out` shows N and `b2_out` shows N+1 in the same cycle.
- R6: The 1B-side capture register takes `b1_in` only at edges with `cap_b1_n` low. The 2B-side capture register takes `b2_in` only at edges with `cap_b2_n` low. Each holds otherwise.
- R7: With `sel_b1` = 1, `a_out` shows the stored 1B-side capture. With `sel_b1` = 0, it shows the stored 2B-side capture. This selection is combinational and does not wait for a clock edge.
- R8: `a_oe` equals the inverse of `oe_a_n` as sampled at the last rising edge, and `b_oe` equals the inverse of `oe_b_n` in the same way. A change on either control between edges has no effect on the enables until the next edge.
- R9: The two ports are enabled independently. While `a_oe` is 0, `a_out` reads 0. While `b_oe` is 0, both `b1_out` and `b2_out` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | W | Narrow port input data |
| a_out | output | W | Narrow port output data (zero when disabled) |
| a_oe | output | 1 | Narrow port drive enable |
| b1_in | input | W | Wide low-half input data |
| b1_out | output | W | Wide 1B half output (zero when disabled) |
| b2_in | input | W | Wide 2B half input data |
| b2_out | output | W | Wide 2B half output (zero when disabled) |
| b_oe | output | 1 | Wide port drive enable |
| ld_a1_n | input | 1 | Active-low load for the 1B pipeline |
| ld_a2_n | input | 1 | Active-low load for the 2B register |
| cap_b1_n | input | 1 | Active-low capture of the 1B input |
| cap_b2_n | input | 1 | Active-low capture of the 2B input |
| sel_b1 | input | 1 | 1 selects the stored 1B half for A, 0 the 2B half |
| oe_a_n | input | 1 | Active-low narrow port enable, sampled on clock |
| oe_b_n | input | 1 | Active-low wide port enable, sampled on clock |

## Verification
A long sweep drives all four combinations of the two A-side load strobes, in patterns of different periods. A mismatch on 1B separates a pipeline of depth one or three from the required depth of two. A mismatch on 2B shows that one strobe has leaked into the other path. The same sweep steps the B-side captures, the select and both direction controls through independent periods. This separates a swapped select polarity, a missing capture hold and an unregistered enable. Directed cases cover the reset state, the pairing of two narrow words into one wide word, and an enable change between edges that must not appear before the next edge.

// File: rtl/bx_pkg.sv
package bx_pkg;
   // registered drive enables of the two ports, active high
   typedef struct packed {
      logic a_en;
      logic b_en;
   } bx_oe_t;

   localparam int BX_MIN_WIDTH = 1;
   localparam int BX_MIN_STAGES = 1;
endpackage

// File: rtl/bx_a2b_path.sv
module bx_a2b_path #(
   parameter int W         = 12,
   parameter int A1_STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] a_in,
   input  logic         ld1_n,
   input  logic         ld2_n,
   output logic [W-1:0] b1_q,
   output logic [W-1:0] b2_q
);
   localparam int LAST = A1_STAGES - 1;

   initial begin
      if (W < bx_pkg::BX_MIN_WIDTH) $error("bx_a2b_path: W must be at least 1");
      if (A1_STAGES < bx_pkg::BX_MIN_STAGES) $error("bx_a2b_path: A1_STAGES must be at least 1");
   end

   logic [A1_STAGES-1:0][W-1:0] pipe;
   logic [W-1:0]                half2;

   // 1B pipeline: every stage advances together under ld1_n
   always_ff @(posedge clk) begin
      if (rst) begin
         pipe <= '0;
      end else if (!ld1_n) begin
         for (int s = A1_STAGES - 1; s > 0; s--) begin
            pipe[s] <= pipe[s-1];
         end
         pipe[0] <= a_in;
      end
   end

   // 2B single register under ld2_n
   always_ff @(posedge clk) begin
      if (rst)         half2 <= '0;
      else if (!ld2_n) half2 <= a_in;
   end

   assign b1_q = pipe[LAST];
   assign b2_q = half2;

   // R3
   pipe_hold_chk: assert property (@(posedge clk) disable iff (rst)
      ld1_n |=> $stable(pipe));

   generate
      if (A1_STAGES >= 2) begin : g_deep
         // R2
         pipe_shift_chk: assert property (@(posedge clk) disable iff (rst)
            !ld1_n |=> (pipe[LAST] == $past(pipe[LAST-1])));
      end
   endgenerate

   // R2
   pipe_entry_chk: assert property (@(posedge clk) disable iff (rst)
      !ld1_n |=> (pipe[0] == $past(a_in)));

   // R4
   half2_hold_chk: assert property (@(posedge clk) disable iff (rst)
      ld2_n |=> $stable(half2));
endmodule

// File: rtl/bx_b2a_path.sv
module bx_b2a_path #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] b1_in,
   input  logic [W-1:0] b2_in,
   input  logic         cap1_n,
   input  logic         cap2_n,
   input  logic         sel_b1,
   output logic [W-1:0] a_q
);
   initial begin
      if (W < bx_pkg::BX_MIN_WIDTH) $error("bx_b2a_path: W must be at least 1");
   end

   logic [W-1:0] held1;
   logic [W-1:0] held2;

   always_ff @(posedge clk) begin
      if (rst)          held1 <= '0;
      else if (!cap1_n) held1 <= b1_in;
   end

   always_ff @(posedge clk) begin
      if (rst)          held2 <= '0;
      else if (!cap2_n) held2 <= b2_in;
   end

   // select is not registered
   always_comb a_q = sel_b1 ? held1 : held2;

   // R6
   held1_hold_chk: assert property (@(posedge clk) disable iff (rst)
      cap1_n |=> $stable(held1));

   // R6
   held2_load_chk: assert property (@(posedge clk) disable iff (rst)
      !cap2_n |=> (held2 == $past(b2_in)));
endmodule

// File: rtl/bx_oe_sync.sv
module bx_oe_sync (
   input  logic           clk,
   input  logic           rst,
   input  logic           oe_a_n,
   input  logic           oe_b_n,
   output bx_pkg::bx_oe_t en
);
   logic oea_q;
   logic oeb_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         oea_q <= 1'b1;
         oeb_q <= 1'b1;
      end else begin
         oea_q <= oe_a_n;
         oeb_q <= oe_b_n;
      end
   end

   assign en.a_en = !oea_q;
   assign en.b_en = !oeb_q;

   // R1
   oe_reset_chk: assert property (@(posedge clk)
      rst |=> (!en.a_en && !en.b_en));

   // R8
   oe_follow_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> ((en.a_en == !$past(oe_a_n)) && (en.b_en == !$past(oe_b_n))));
endmodule

// File: rtl/bus_exchanger_nw.sv
module bus_exchanger_nw #(
   parameter int W             = 12,
   parameter int A1_STAGES     = 2,
   parameter bit ZERO_WHEN_OFF = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] a_in,
   output logic [W-1:0] a_out,
   output logic         a_oe,
   input  logic [W-1:0] b1_in,
   output logic [W-1:0] b1_out,
   input  logic [W-1:0] b2_in,
   output logic [W-1:0] b2_out,
   output logic         b_oe,
   input  logic         ld_a1_n,
   input  logic         ld_a2_n,
   input  logic         cap_b1_n,
   input  logic         cap_b2_n,
   input  logic         sel_b1,
   input  logic         oe_a_n,
   input  logic         oe_b_n
);
   initial begin
      if (W < bx_pkg::BX_MIN_WIDTH) $error("bus_exchanger_nw: W must be at least 1");
   end

   logic [W-1:0]   wide1;
   logic [W-1:0]   wide2;
   logic [W-1:0]   narrow;
   bx_pkg::bx_oe_t en;

   bx_a2b_path #(.W(W), .A1_STAGES(A1_STAGES)) u_a2b (
      .clk  (clk),
      .rst  (rst),
      .a_in (a_in),
      .ld1_n(ld_a1_n),
      .ld2_n(ld_a2_n),
      .b1_q (wide1),
      .b2_q (wide2)
   );

   bx_b2a_path #(.W(W)) u_b2a (
      .clk   (clk),
      .rst   (rst),
      .b1_in (b1_in),
      .b2_in (b2_in),
      .cap1_n(cap_b1_n),
      .cap2_n(cap_b2_n),
      .sel_b1(sel_b1),
      .a_q   (narrow)
   );

   bx_oe_sync u_oe (
      .clk   (clk),
      .rst   (rst),
      .oe_a_n(oe_a_n),
      .oe_b_n(oe_b_n),
      .en    (en)
   );

   assign a_oe = en.a_en;
   assign b_oe = en.b_en;

   generate
      if (ZERO_WHEN_OFF) begin : g_gated
         assign a_out  = en.a_en ? narrow : '0;
         assign b1_out = en.b_en ? wide1  : '0;
         assign b2_out = en.b_en ? wide2  : '0;
      end else begin : g_raw
         assign a_out  = narrow;
         assign b1_out = wide1;
         assign b2_out = wide2;
      end
   endgenerate

   // R5
   pair_chk: assert property (@(posedge clk) disable iff (rst)
      (!ld_a1_n && !ld_a2_n) |=> (wide2 == $past(a_in)));
endmodule

// File: tb/test_bus_exchanger_nw.sv
module test_bus_exchanger_nw;
   localparam int W = 12;
   localparam logic [W-1:0] MASK = '1;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [W-1:0] a_in = '0, b1_in = '0, b2_in = '0;
   logic [W-1:0] a_out, b1_out, b2_out;
   logic a_oe, b_oe;
   logic ld_a1_n = 1'b1, ld_a2_n = 1'b1, cap_b1_n = 1'b1, cap_b2_n = 1'b1;
   logic sel_b1 = 1'b0, oe_a_n = 1'b1, oe_b_n = 1'b1;

   int checks = 0;
   int errors = 0;

   // bench model state
   logic [W-1:0] m_s1 = '0, m_s2 = '0, m_h2 = '0, m_c1 = '0, m_c2 = '0;
   logic m_aoe = 1'b0, m_boe = 1'b0;

   always #4 clk = ~clk;

   bus_exchanger_nw #(.W(W)) i_bus_exchanger_nw (
      .clk(clk), .rst(rst), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
      .b1_in(b1_in), .b1_out(b1_out), .b2_in(b2_in), .b2_out(b2_out), .b_oe(b_oe),
      .ld_a1_n(ld_a1_n), .ld_a2_n(ld_a2_n), .cap_b1_n(cap_b1_n), .cap_b2_n(cap_b2_n),
      .sel_b1(sel_b1), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // one clock edge, model updated with the inputs present at that edge
   task automatic tick();
      @(posedge clk);
      if (rst) begin
         m_s1 = '0; m_s2 = '0; m_h2 = '0; m_c1 = '0; m_c2 = '0;
         m_aoe = 1'b0; m_boe = 1'b0;
      end else begin
         if (!ld_a1_n) begin m_s2 = m_s1; m_s1 = a_in; end
         if (!ld_a2_n) m_h2 = a_in;
         if (!cap_b1_n) m_c1 = b1_in;
         if (!cap_b2_n) m_c2 = b2_in;
         m_aoe = !oe_a_n;
         m_boe = !oe_b_n;
      end
      #2;
   endtask

   task automatic check_all(input string ctx);
      logic [W-1:0] e_a;
      e_a = m_aoe ? (sel_b1 ? m_c1 : m_c2) : '0;
      chk({ctx, " R2 R3 b1_out"}, b1_out, m_boe ? m_s2 : '0);
      chk({ctx, " R4 b2_out"},    b2_out, m_boe ? m_h2 : '0);
      chk({ctx, " R6 R7 a_out"},  a_out,  e_a);
      chk({ctx, " R8 R9 a_oe"},   a_oe,   m_aoe);
      chk({ctx, " R8 R9 b_oe"},   b_oe,   m_boe);
   endtask

   initial begin
      #(8 * 200000);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // R1: reset state
      a_in = 12'hABC; b1_in = 12'h123; b2_in = 12'h456;
      ld_a1_n = 1'b0; ld_a2_n = 1'b0; cap_b1_n = 1'b0; cap_b2_n = 1'b0;
      oe_a_n = 1'b0; oe_b_n = 1'b0;
      tick(); tick();
      chk("R1 a_oe after reset", a_oe, 0);
      chk("R1 b_oe after reset", b_oe, 0);
      chk("R1 b1_out after reset", b1_out, 0);
      chk("R1 b2_out after reset", b2_out, 0);
      ld_a1_n = 1'b1; ld_a2_n = 1'b1; cap_b1_n = 1'b1; cap_b2_n = 1'b1;
      rst = 1'b0;
      tick();
      check_all("R1 first");

      // R5: pairing of two narrow words
      a_in = 12'h111; ld_a1_n = 1'b0; ld_a2_n = 1'b1;
      tick();
      chk("R2 one load not yet at 1B", b1_out, 0);
      a_in = 12'h222; ld_a1_n = 1'b0; ld_a2_n = 1'b0;
      tick();
      chk("R5 b1_out word N", b1_out, 12'h111);
      chk("R5 b2_out word N+1", b2_out, 12'h222);
      ld_a1_n = 1'b1; ld_a2_n = 1'b1; a_in = 12'h333;
      tick();
      chk("R3 1B held", b1_out, 12'h111);
      chk("R4 2B held", b2_out, 12'h222);

      // R8: control change between edges has no effect before the edge
      oe_b_n = 1'b1;
      #1;
      chk("R8 b_oe before edge", b_oe, 1);
      tick();
      chk("R8 b_oe after edge", b_oe, 0);
      chk("R9 b1_out disabled", b1_out, 0);
      chk("R9 a_oe independent", a_oe, 1);

      // R7: combinational select
      b1_in = 12'h5A5; b2_in = 12'hC3C; cap_b1_n = 1'b0; cap_b2_n = 1'b0;
      tick();
      cap_b1_n = 1'b1; cap_b2_n = 1'b1;
      sel_b1 = 1'b1; #1;
      chk("R7 sel high picks 1B", a_out, 12'h5A5);
      sel_b1 = 1'b0; #1;
      chk("R7 sel low picks 2B", a_out, 12'hC3C);
      tick();

      // sweep over all strobe combinations with differing periods
      for (int i = 0; i < 400; i++) begin
         a_in     = W'((i * 149 + 7) & MASK);
         b1_in    = W'((i * 211 + 3) & MASK);
         b2_in    = W'((i * 83 + 1000) & MASK);
         ld_a1_n  = (i % 3) == 1;
         ld_a2_n  = ((i / 2) % 2) == 1;
         cap_b1_n = (i % 5) == 2;
         cap_b2_n = (i % 4) == 0;
         sel_b1   = ((i / 3) % 2) == 1;
         oe_a_n   = (i % 7) >= 5;
         oe_b_n   = (i % 11) >= 8;
         tick();
         check_all("sweep");
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule